// File: doc/BRIEF.md
# Health Failure Alert Accumulator

This block gathers the one-cycle failure pulses produced by a bank of entropy health tests and decides when those failures are serious enough to raise an alert. Each test has an enable; only enabled failures count. A per-test saturating counter records how often each test has failed, and an aggregate counter records failure events across all tests, where any number of tests failing in the same cycle counts as one event.

The aggregate counter tracks runs of consecutive failing windows. A window-end strobe marks each window boundary. A window that closes without any counted failure resets the aggregate to zero. When the aggregate reaches the programmed limit, a sticky alert rises and stays high until software issues a clear. The limit is supplied as a value together with its bitwise complement. A pair that does not match sets a sticky recoverable-error flag, and that limit is never used to raise the alert. A limit of zero disables alerting.

Top module: `health_alert_accum`

## Requirements
- R1: After reset every per-test count, the aggregate count, the alert and the error flag read zero.
- R2: An enabled test's fail pulse raises that test's count by one, visible on the cycle after the pulse edge.
- R3: A fail pulse on a test whose enable bit is 0 changes neither that test's count nor the aggregate count.
- R4: Per-test counts saturate at 2^CNT_W-1 (15 by default) and hold there under further pulses.
- R5: A clear strobe zeroes all counts, the aggregate and the alert on the next cycle, and takes priority over pulses in the same cycle.
- R6: One or more enabled tests failing in the same cycle raise the aggregate count by exactly one.
- R7: A window-end strobe in a cycle with no enabled failure, closing a window that saw no enabled failure since the previous window end or clear, sets the aggregate count to zero. A window that contained a failure leaves the count unchanged.
- R8: The aggregate count saturates at 2^THR_W-1 (15 by default).
- R9: With a consistent nonzero limit L, the alert rises in the same cycle that the aggregate count first reads L or more, for every L from 1 to the maximum. It stays high until a clear.
- R10: If the limit field is not the exact bitwise inverse of the complement field, the error flag reads 1 on the next cycle and stays high until a clear is given while the pair is consistent. While the pair is inconsistent the alert does not rise.
- R11: A consistent limit of zero (value 0, complement all ones) never raises the alert and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fail_pulse_i | input | NUM_TESTS | Per-test failure pulses |
| test_en_i | input | NUM_TESTS | Per-test contribution enables |
| win_end_i | input | 1 | Window boundary strobe |
| thr_val_i | input | THR_W | Alert limit |
| thr_inv_i | input | THR_W | Bitwise complement of the alert limit |
| clr_i | input | 1 | Software clear of counts, alert and error flag |
| alert_o | output | 1 | Sticky alert |
| recov_err_o | output | 1 | Sticky limit-pair mismatch flag |
| agg_cnt_o | output | THR_W | Aggregate failure-event count |
| test_cnt_o | output | NUM_TESTS*CNT_W | Per-test counts, test i at bits [i*CNT_W +: CNT_W] |

## Verification
The bench sweeps every limit from 1 to 15. It checks that the alert rises exactly on the cycle the aggregate reaches the limit. An off-by-one comparison would fire a cycle early or late, and a limit of 1 or 2 is where such a slip shows first. It drives all-tests-at-once failures and every enable mask. A design that summed the failing tests would step the aggregate by more than one, and one that ignored the mask would count disabled tests. Long pulse runs push both counter kinds past their maximum, which catches wrap-around. Mismatched pairs, a zero limit, a clear with simultaneous pulses and empty windows are aimed at designs that trust a corrupted limit, give pulses priority over the clear, or never reset the run.

// File: rtl/hfa_pkg.sv
package hfa_pkg;
  localparam int unsigned DEF_TESTS = 4;
  localparam int unsigned DEF_CNT_W = 4;
  localparam int unsigned DEF_THR_W = 4;
endpackage

// File: rtl/hfa_thr_check.sv
module hfa_thr_check #(
  parameter int unsigned THR_W = hfa_pkg::DEF_THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [THR_W-1:0] thr_val_i,
  input  logic [THR_W-1:0] thr_inv_i,
  output logic             thr_ok_o,
  output logic             recov_err_o
);
  logic pair_match;
  logic err_d, err_q;

  assign pair_match = (thr_val_i == ~thr_inv_i);
  assign thr_ok_o   = pair_match && (thr_val_i != '0);

  always_comb begin
    err_d = !pair_match || (err_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign recov_err_o = err_q;

  assert_err_on_mismatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_val_i != ~thr_inv_i) |=> recov_err_o);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_err_o && !clr_i) |=> recov_err_o);
endmodule

// File: rtl/hfa_test_cnt.sv
module hfa_test_cnt #(
  parameter int unsigned CNT_W = hfa_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (hit_i && (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && !clr_i) |=> $stable(cnt_o));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_o == CNT_MAX) && !clr_i) |=> (cnt_o == CNT_MAX));
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/hfa_agg.sv
module hfa_agg #(
  parameter int unsigned THR_W = hfa_pkg::DEF_THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             event_i,
  input  logic             win_end_i,
  input  logic             thr_ok_i,
  input  logic [THR_W-1:0] thr_val_i,
  output logic [THR_W-1:0] agg_o,
  output logic             alert_o
);
  localparam logic [THR_W-1:0] AGG_MAX = '1;

  logic [THR_W-1:0] agg_d, agg_q;
  logic             win_d, win_q;
  logic             alert_d, alert_q;

  always_comb begin
    agg_d = agg_q;
    win_d = win_q;
    if (clr_i) begin
      agg_d = '0;
      win_d = 1'b0;
    end else begin
      if (event_i) begin
        if (agg_q != AGG_MAX) agg_d = agg_q + 1'b1;
      end else if (win_end_i && !win_q) begin
        agg_d = '0;
      end
      if (win_end_i)    win_d = 1'b0;
      else if (event_i) win_d = 1'b1;
    end
    alert_d = !clr_i && (alert_q || (thr_ok_i && (agg_d >= thr_val_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agg_q   <= '0;
      win_q   <= 1'b0;
      alert_q <= 1'b0;
    end else begin
      agg_q   <= agg_d;
      win_q   <= win_d;
      alert_q <= alert_d;
    end
  end

  assign agg_o   = agg_q;
  assign alert_o = alert_q;

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (event_i && !clr_i && (agg_o != AGG_MAX)) |=> (agg_o == $past(agg_o) + 1'b1));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((agg_o == AGG_MAX) && !clr_i && !win_end_i) |=> (agg_o == AGG_MAX));
  assert_alert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_o && !clr_i) |=> alert_o);
  assert_no_alert_bad_thr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_ok_i && !alert_o) |=> !alert_o);
  assert_clear_alert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!alert_o && (agg_o == '0)));
endmodule

// File: rtl/health_alert_accum.sv
module health_alert_accum #(
  parameter int unsigned NUM_TESTS = hfa_pkg::DEF_TESTS,
  parameter int unsigned CNT_W     = hfa_pkg::DEF_CNT_W,
  parameter int unsigned THR_W     = hfa_pkg::DEF_THR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_TESTS-1:0]       fail_pulse_i,
  input  logic [NUM_TESTS-1:0]       test_en_i,
  input  logic                       win_end_i,
  input  logic [THR_W-1:0]           thr_val_i,
  input  logic [THR_W-1:0]           thr_inv_i,
  input  logic                       clr_i,
  output logic                       alert_o,
  output logic                       recov_err_o,
  output logic [THR_W-1:0]           agg_cnt_o,
  output logic [NUM_TESTS*CNT_W-1:0] test_cnt_o
);
  logic [NUM_TESTS-1:0] hits;
  logic                 any_hit;
  logic                 thr_ok;

  assign hits    = fail_pulse_i & test_en_i;
  assign any_hit = |hits;

  for (genvar i = 0; i < NUM_TESTS; i++) begin : g_test
    hfa_test_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr_i),
      .hit_i (hits[i]),
      .cnt_o (test_cnt_o[i*CNT_W +: CNT_W])
    );
  end

  hfa_thr_check #(.THR_W(THR_W)) u_thr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .thr_val_i   (thr_val_i),
    .thr_inv_i   (thr_inv_i),
    .thr_ok_o    (thr_ok),
    .recov_err_o (recov_err_o)
  );

  hfa_agg #(.THR_W(THR_W)) u_agg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .event_i   (any_hit),
    .win_end_i (win_end_i),
    .thr_ok_i  (thr_ok),
    .thr_val_i (thr_val_i),
    .agg_o     (agg_cnt_o),
    .alert_o   (alert_o)
  );

  assert_masked_no_agg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((fail_pulse_i & test_en_i) == '0 && !clr_i && !win_end_i) |=> $stable(agg_cnt_o));
  assert_zero_thr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr_val_i == '0) && (thr_inv_i == '1) && !alert_o) |=> !alert_o);
endmodule

// File: tb/sim_health_alert_accum.sv
module sim_health_alert_accum;
  localparam int NT = 4;
  localparam int CW = 4;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NT-1:0] fail, en;
  logic          wend, clr;
  logic [TW-1:0] tv, ti;
  logic          alert, err;
  logic [TW-1:0] agg;
  logic [NT*CW-1:0] cnts;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_cnt [NT];
  int m_agg;
  bit m_win, m_alert, m_err;

  always #4 clk = ~clk;

  health_alert_accum #(.NUM_TESTS(NT), .CNT_W(CW), .THR_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .fail_pulse_i(fail), .test_en_i(en),
    .win_end_i(wend), .thr_val_i(tv), .thr_inv_i(ti), .clr_i(clr),
    .alert_o(alert), .recov_err_o(err), .agg_cnt_o(agg), .test_cnt_o(cnts)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < NT; i++)
      chk({tag, "/R2 count"}, int'(cnts[i*CW +: CW]), m_cnt[i]);
    chk({tag, "/R6 aggregate"}, int'(agg), m_agg);
    chk({tag, "/R9 alert"}, int'(alert), int'(m_alert));
    chk({tag, "/R10 error"}, int'(err), int'(m_err));
  endtask

  // one clock cycle: apply inputs, advance the requirement model, compare
  task automatic cyc(input logic [NT-1:0] f, input logic [NT-1:0] e, input logic w,
                     input logic c, input logic [TW-1:0] v, input logic [TW-1:0] iv,
                     input string tag);
    logic [NT-1:0] h;
    bit ev, ok;
    fail = f; en = e; wend = w; clr = c; tv = v; ti = iv;
    h  = f & e;
    ev = |h;
    ok = (v == ~iv) && (v != 0);
    @(posedge clk);
    for (int i = 0; i < NT; i++) begin
      if (c) m_cnt[i] = 0;
      else if (h[i] && m_cnt[i] < (1 << CW) - 1) m_cnt[i]++;
    end
    if (c) m_agg = 0;
    else if (ev) begin if (m_agg < (1 << TW) - 1) m_agg++; end
    else if (w && !m_win) m_agg = 0;
    if (c || w) m_win = 0; else if (ev) m_win = 1;
    m_alert = !c && (m_alert || (ok && m_agg >= int'(v)));
    m_err   = (v != ~iv) || (m_err && !c);
    #2;
    compare_all(tag);
  endtask

  logic [15:0] lfsr;

  initial begin
    rst_n = 1'b0; fail = '0; en = '0; wend = 1'b0; clr = 1'b0; tv = 4'd1; ti = ~4'd1;
    for (int i = 0; i < NT; i++) m_cnt[i] = 0;
    m_agg = 0; m_win = 0; m_alert = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #2;
    compare_all("R1 reset");
    rst_n = 1'b1;

    // R9 threshold sweep; R4 and R8 saturation reached by 17 pulses
    for (int t = 1; t < (1 << TW); t++) begin
      cyc('0, '1, 1'b0, 1'b1, TW'(t), ~TW'(t), "R5 clear");
      for (int k = 0; k < 17; k++)
        cyc(NT'(1) << (t % NT), '1, 1'b0, 1'b0, TW'(t), ~TW'(t), "R9 sweep R4 R8");
    end

    // R6 all tests at once add a single event
    cyc('0, '1, 1'b0, 1'b1, 4'd3, ~4'd3, "R5 clear");
    for (int k = 0; k < 3; k++)
      cyc('1, '1, 1'b0, 1'b0, 4'd3, ~4'd3, "R6 simultaneous");

    // R3 every enable mask with all tests failing
    for (int m = 0; m < (1 << NT); m++) begin
      cyc('0, '1, 1'b0, 1'b1, 4'd15, ~4'd15, "R5 clear");
      cyc('1, NT'(m), 1'b0, 1'b0, 4'd15, ~4'd15, "R3 mask");
    end

    // R7 windows: failing window keeps, empty window clears
    cyc('0, '1, 1'b0, 1'b1, 4'd15, ~4'd15, "R5 clear");
    cyc(4'b0010, '1, 1'b0, 1'b0, 4'd15, ~4'd15, "R7 fail");
    cyc('0, '1, 1'b1, 1'b0, 4'd15, ~4'd15, "R7 keep");
    cyc(4'b0100, '1, 1'b1, 1'b0, 4'd15, ~4'd15, "R7 fail at end");
    cyc('0, '1, 1'b1, 1'b0, 4'd15, ~4'd15, "R7 empty clears");
    chk("R7 aggregate zero", int'(agg), 0);

    // R10 mismatched pair: error set, alert blocked
    cyc('0, '1, 1'b0, 1'b1, 4'd1, 4'd1, "R10 clear with bad pair");
    chk("R10 error set", int'(err), 1);
    for (int k = 0; k < 4; k++)
      cyc('1, '1, 1'b0, 1'b0, 4'd1, 4'd0, "R10 bad pair");
    chk("R10 no alert", int'(alert), 0);
    cyc('0, '1, 1'b0, 1'b0, 4'd1, ~4'd1, "R10 sticky");
    chk("R10 sticky", int'(err), 1);
    cyc('0, '1, 1'b0, 1'b1, 4'd1, ~4'd1, "R5 clear");
    chk("R10 cleared", int'(err), 0);

    // R11 zero limit never alerts
    for (int k = 0; k < 20; k++)
      cyc('1, '1, 1'b0, 1'b0, 4'd0, 4'hF, "R11 zero limit");
    chk("R11 no alert", int'(alert), 0);

    // R5 clear wins over simultaneous pulses
    cyc('1, '1, 1'b0, 1'b1, 4'd2, ~4'd2, "R5 clear priority");
    chk("R5 aggregate zero", int'(agg), 0);

    // pseudo-random mix of pulses, masks, windows and limits
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3:0] & {4{lfsr[4]}}, lfsr[7:4] | 4'b0001, lfsr[8] & lfsr[9],
          (lfsr[15:11] == 5'd0), 4'(1 + (k / 50)), ~4'(1 + (k / 50)), "mix R2 R7 R9");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule